// File: doc/BRIEF.md
# I2C Transaction List Sequencer

This block runs a list of I2C transfers back to back on top of a byte-level I2C master engine that reports each bus step as a status code. Each list entry (descriptor) holds a device address byte, whose bit 0 selects read (1) or write (0), a byte count and a base address into a byte buffer. For each status event, the sequencer supplies the address or the next write byte, stores incoming read bytes and sets the acknowledge level for the next received byte. It requests a repeated start between transfers and a stop after the final one or on any failure. It then reports a result code with a one-cycle done pulse.

Descriptors and the byte buffer live in a small register file next to the block. The sequencer reads them combinationally through an index and an address, and writes read bytes through a write strobe in the cycle the byte event is handled. Engine commands (`cmd_*`, `tx_load_o`) and the event-clear strobe are registered. Each is asserted in the cycle after the event that caused it. The engine is expected to drop `evt_valid_i` after it sees `evt_clr_o`. While `evt_clr_o` is high, the sequencer takes no new event.

Top module: `i2c_txn_seq`

## Requirements
- R1: A start request with a transfer count of 0 raises `done_o` in the next cycle with result 0 (OK). No bus command is issued and `busy_o` stays low.
- R2: A start request with a non-zero count pulses `cmd_start_o` in the next cycle. `busy_o` stays high from that cycle until the cycle of `done_o`, and start requests made while busy are ignored.
- R3: On event code 1 (start done) or 2 (repeated start done), the address byte of the current descriptor is loaded into the engine via `tx_load_o`/`tx_byte_o`. Descriptors are used in index order from 0.
- R4: In write mode, on code 3 (address ACKed) or 5 (data ACKed), the next buffer byte is loaded if any remain. Bytes run upward from the descriptor base. When the count is used up, the transfer ends.
- R5: Code 6 (data NAKed) while bytes still remain ends the list with a stop and result 3. Code 6 after the final byte of the transfer is handled like code 5.
- R6: Code 4 (write address NAKed) ends the list with a stop and result 1. Code 9 (read address NAKed) ends it with a stop and result 2. No later descriptor is started.
- R7: In read mode, each code 10 (byte received, ACK sent) or 11 (byte received, NAK sent) stores `evt_rdata_i` at the next buffer address from the base and counts the byte. Code 8 (read address ACKed) does no store. After either kind of event, `ack_o` is set to 1 while more than one byte is still to come and to 0 when exactly one is. With none left, the transfer ends. A zero-length read stores nothing.
- R8: When a transfer that is not the last ends, `cmd_restart_o` is pulsed and the next descriptor is used. When the last transfer ends, `cmd_stop_o` is pulsed with result 0.
- R9: Any other event code, including 0 and 7, ends the list with a stop and result 4.
- R10: Every event taken while busy is answered by exactly one `evt_clr_o` pulse in the following cycle.
- R11: `done_o` is a one-cycle pulse, and `result_o` keeps its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request |
| num_txn_i | input | NTXN_W | Number of descriptors to run |
| busy_o | output | 1 | List in progress |
| done_o | output | 1 | Completion pulse |
| result_o | output | 3 | 0 OK, 1 write addr NAK, 2 read addr NAK, 3 early data NAK, 4 internal error |
| desc_idx_o | output | NTXN_W | Current descriptor index |
| desc_addr_i | input | 8 | Device address byte of descriptor |
| desc_len_i | input | CNT_W | Byte count of descriptor |
| desc_base_i | input | ADDR_W | Buffer base of descriptor |
| buf_addr_o | output | ADDR_W | Buffer address |
| buf_rdata_i | input | 8 | Buffer read data |
| buf_we_o | output | 1 | Buffer write strobe |
| buf_wdata_o | output | 8 | Buffer write data |
| evt_valid_i | input | 1 | Engine event flag |
| evt_code_i | input | 4 | Engine status code |
| evt_rdata_i | input | 8 | Byte received by engine |
| evt_clr_o | output | 1 | Clear engine event flag |
| cmd_start_o | output | 1 | Request start condition |
| cmd_restart_o | output | 1 | Request repeated start |
| cmd_stop_o | output | 1 | Request stop condition |
| tx_load_o | output | 1 | Load byte into engine |
| tx_byte_o | output | 8 | Byte to transmit |
| ack_o | output | 1 | Acknowledge level for next received byte |

## Verification
The bench builds the block with NTXN_W=3, CNT_W=4 and ADDR_W=4, so a 16-byte buffer and an eight-entry descriptor table are enough. It runs three-descriptor chains (write, read, write) for every pair of write and read lengths from 0 to 4. That sweep covers zero-length transfers in both directions, the single-byte read that must be NAKed at once, and the byte just past a read area. A scripted engine model injects address NAKs on either descriptor, data NAKs on a middle byte and on the final byte, an unknown status code, and a second start while busy.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned RES_W  = 3;

  typedef enum logic [CODE_W-1:0] {
    EV_START     = 4'h1,
    EV_RESTART   = 4'h2,
    EV_WADDR_ACK = 4'h3,
    EV_WADDR_NAK = 4'h4,
    EV_WDATA_ACK = 4'h5,
    EV_WDATA_NAK = 4'h6,
    EV_RADDR_ACK = 4'h8,
    EV_RADDR_NAK = 4'h9,
    EV_RDATA_ACK = 4'hA,
    EV_RDATA_NAK = 4'hB
  } ev_code_e;

  typedef enum logic [RES_W-1:0] {
    RES_OK        = 3'd0,
    RES_WADDR_NAK = 3'd1,
    RES_RADDR_NAK = 3'd2,
    RES_DATA_NAK  = 3'd3,
    RES_INTERNAL  = 3'd4
  } result_e;

  typedef enum logic [2:0] {
    ACT_ADDR,
    ACT_WR_ACK,
    ACT_WR_NAK,
    ACT_RD_ADDR,
    ACT_RD_DATA,
    ACT_WA_NAK,
    ACT_RA_NAK,
    ACT_BAD
  } act_e;
endpackage

// File: rtl/i2cseq_decode.sv
module i2cseq_decode
  import i2cseq_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output act_e              act_o
);
  always_comb begin
    case (code_i)
      EV_START, EV_RESTART:         act_o = ACT_ADDR;
      EV_WADDR_ACK, EV_WDATA_ACK:   act_o = ACT_WR_ACK;
      EV_WDATA_NAK:                 act_o = ACT_WR_NAK;
      EV_RADDR_ACK:                 act_o = ACT_RD_ADDR;
      EV_RDATA_ACK, EV_RDATA_NAK:   act_o = ACT_RD_DATA;
      EV_WADDR_NAK:                 act_o = ACT_WA_NAK;
      EV_RADDR_NAK:                 act_o = ACT_RA_NAK;
      default:                      act_o = ACT_BAD;
    endcase
  end
endmodule

// File: rtl/i2cseq_cursor.sv
module i2cseq_cursor #(
  parameter int unsigned NTXN_W = 4,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic [NTXN_W-1:0] num_i,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              step_i,
  input  logic              adv_i,
  output logic [NTXN_W-1:0] idx_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [CNT_W-1:0]  rem_o,
  output logic              last_o
);
  logic [NTXN_W-1:0] idx_q, left_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [CNT_W-1:0]  rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      left_q <= '0;
    end else if (init_i) begin
      idx_q  <= '0;
      left_q <= num_i;
    end else if (adv_i) begin
      idx_q  <= idx_q + 1'b1;
      left_q <= left_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      rem_q <= '0;
    end else if (load_i) begin
      ptr_q <= base_i;
      rem_q <= len_i;
    end else if (step_i) begin
      ptr_q <= ptr_q + 1'b1;
      rem_q <= rem_q - 1'b1;
    end
  end

  assign idx_o  = idx_q;
  assign ptr_o  = ptr_q;
  assign rem_o  = rem_q;
  assign last_o = (left_q == NTXN_W'(1));

  // R7: byte stepping never runs past the descriptor count
  a_r7_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> rem_q != '0);
  // R8: advancing only happens with more than one transfer left
  a_r8_adv_not_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> left_q > NTXN_W'(1));
endmodule

// File: rtl/i2cseq_ctrl.sv
module i2cseq_ctrl
  import i2cseq_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              num_zero_i,
  input  logic              evt_valid_i,
  input  act_e              act_i,
  input  logic [CNT_W-1:0]  rem_i,
  input  logic              last_i,
  input  logic [BYTE_W-1:0] desc_addr_i,
  input  logic [BYTE_W-1:0] buf_rdata_i,
  output logic              init_o,
  output logic              load_o,
  output logic              step_o,
  output logic              adv_o,
  output logic              buf_we_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [RES_W-1:0]  result_o,
  output logic              evt_clr_o,
  output logic              cmd_start_o,
  output logic              cmd_restart_o,
  output logic              cmd_stop_o,
  output logic              tx_load_o,
  output logic [BYTE_W-1:0] tx_byte_o,
  output logic              ack_o
);
  logic busy_q, done_q, clr_q, start_q, restart_q, stop_q, tx_q, ack_q;
  logic [BYTE_W-1:0] byte_q;
  result_e res_q;

  logic busy_d, clr_d, start_d, restart_d, stop_d, tx_d, ack_d;
  logic [BYTE_W-1:0] byte_d;
  result_e res_d, abort_res;
  logic accept, take, finish, end_txn, abort;
  logic rem_zero, rem_one, rem_two;

  assign rem_zero = (rem_i == '0);
  assign rem_one  = (rem_i == CNT_W'(1));
  assign rem_two  = (rem_i == CNT_W'(2));
  assign accept   = start_i & ~busy_q;
  // event flag still high while its clear is being issued
  assign take     = busy_q & evt_valid_i & ~clr_q;

  always_comb begin
    init_o    = 1'b0;
    load_o    = 1'b0;
    step_o    = 1'b0;
    adv_o     = 1'b0;
    buf_we_o  = 1'b0;
    clr_d     = 1'b0;
    start_d   = 1'b0;
    restart_d = 1'b0;
    stop_d    = 1'b0;
    tx_d      = 1'b0;
    byte_d    = byte_q;
    ack_d     = ack_q;
    finish    = 1'b0;
    end_txn   = 1'b0;
    abort     = 1'b0;
    abort_res = RES_INTERNAL;
    res_d     = RES_OK;

    if (accept) begin
      if (num_zero_i) finish = 1'b1;
      else begin
        init_o  = 1'b1;
        start_d = 1'b1;
      end
    end

    if (take) begin
      clr_d = 1'b1;
      case (act_i)
        ACT_ADDR: begin
          load_o = 1'b1;
          tx_d   = 1'b1;
          byte_d = desc_addr_i;
        end
        ACT_WR_ACK: begin
          if (rem_zero) end_txn = 1'b1;
          else begin
            tx_d   = 1'b1;
            byte_d = buf_rdata_i;
            step_o = 1'b1;
          end
        end
        ACT_WR_NAK: begin
          if (rem_zero) end_txn = 1'b1;
          else begin
            abort     = 1'b1;
            abort_res = RES_DATA_NAK;
          end
        end
        ACT_RD_ADDR: begin
          if (rem_zero) end_txn = 1'b1;
          else ack_d = ~rem_one;
        end
        ACT_RD_DATA: begin
          if (rem_zero) abort = 1'b1;
          else begin
            buf_we_o = 1'b1;
            step_o   = 1'b1;
            if (rem_one) end_txn = 1'b1;
            else ack_d = ~rem_two;
          end
        end
        ACT_WA_NAK: begin
          abort     = 1'b1;
          abort_res = RES_WADDR_NAK;
        end
        ACT_RA_NAK: begin
          abort     = 1'b1;
          abort_res = RES_RADDR_NAK;
        end
        default: abort = 1'b1;
      endcase
    end

    if (end_txn) begin
      if (last_i) begin
        stop_d = 1'b1;
        finish = 1'b1;
      end else begin
        restart_d = 1'b1;
        adv_o     = 1'b1;
      end
    end
    if (abort) begin
      stop_d = 1'b1;
      finish = 1'b1;
      res_d  = abort_res;
    end

    if (accept && !num_zero_i) busy_d = 1'b1;
    else if (finish)           busy_d = 1'b0;
    else                       busy_d = busy_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      clr_q     <= 1'b0;
      start_q   <= 1'b0;
      restart_q <= 1'b0;
      stop_q    <= 1'b0;
      tx_q      <= 1'b0;
      byte_q    <= '0;
      ack_q     <= 1'b1;
      res_q     <= RES_OK;
    end else begin
      busy_q    <= busy_d;
      done_q    <= finish;
      clr_q     <= clr_d;
      start_q   <= start_d;
      restart_q <= restart_d;
      stop_q    <= stop_d;
      tx_q      <= tx_d;
      byte_q    <= byte_d;
      ack_q     <= ack_d;
      if (finish) res_q <= res_d;
    end
  end

  assign busy_o        = busy_q;
  assign done_o        = done_q;
  assign result_o      = res_q;
  assign evt_clr_o     = clr_q;
  assign cmd_start_o   = start_q;
  assign cmd_restart_o = restart_q;
  assign cmd_stop_o    = stop_q;
  assign tx_load_o     = tx_q;
  assign tx_byte_o     = byte_q;
  assign ack_o         = ack_q;

  a_r2_no_start_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !cmd_start_o);
  a_r10_clr_follows_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && evt_valid_i && !evt_clr_o) |=> evt_clr_o);
  a_r11_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_stop_ends_list: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stop_o |-> (done_o && !busy_o));
  a_r8_one_command: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_start_o, cmd_restart_o, cmd_stop_o}));
  a_r11_result_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> result_o <= 3'd4);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!tx_load_o && !cmd_restart_o && !buf_we_o));
endmodule

// File: rtl/i2c_txn_seq.sv
module i2c_txn_seq
  import i2cseq_pkg::*;
#(
  parameter int unsigned NTXN_W = 4,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [NTXN_W-1:0] num_txn_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [2:0]        result_o,
  output logic [NTXN_W-1:0] desc_idx_o,
  input  logic [7:0]        desc_addr_i,
  input  logic [CNT_W-1:0]  desc_len_i,
  input  logic [ADDR_W-1:0] desc_base_i,
  output logic [ADDR_W-1:0] buf_addr_o,
  input  logic [7:0]        buf_rdata_i,
  output logic              buf_we_o,
  output logic [7:0]        buf_wdata_o,
  input  logic              evt_valid_i,
  input  logic [3:0]        evt_code_i,
  input  logic [7:0]        evt_rdata_i,
  output logic              evt_clr_o,
  output logic              cmd_start_o,
  output logic              cmd_restart_o,
  output logic              cmd_stop_o,
  output logic              tx_load_o,
  output logic [7:0]        tx_byte_o,
  output logic              ack_o
);
  act_e             act;
  logic             init, load, step, adv, last;
  logic [CNT_W-1:0] rem;

  i2cseq_decode u_decode (
    .code_i (evt_code_i),
    .act_o  (act)
  );

  i2cseq_cursor #(
    .NTXN_W (NTXN_W),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
  ) u_cursor (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (init),
    .num_i  (num_txn_i),
    .load_i (load),
    .len_i  (desc_len_i),
    .base_i (desc_base_i),
    .step_i (step),
    .adv_i  (adv),
    .idx_o  (desc_idx_o),
    .ptr_o  (buf_addr_o),
    .rem_o  (rem),
    .last_o (last)
  );

  i2cseq_ctrl #(
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .num_zero_i    (num_txn_i == '0),
    .evt_valid_i   (evt_valid_i),
    .act_i         (act),
    .rem_i         (rem),
    .last_i        (last),
    .desc_addr_i   (desc_addr_i),
    .buf_rdata_i   (buf_rdata_i),
    .init_o        (init),
    .load_o        (load),
    .step_o        (step),
    .adv_o         (adv),
    .buf_we_o      (buf_we_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .result_o      (result_o),
    .evt_clr_o     (evt_clr_o),
    .cmd_start_o   (cmd_start_o),
    .cmd_restart_o (cmd_restart_o),
    .cmd_stop_o    (cmd_stop_o),
    .tx_load_o     (tx_load_o),
    .tx_byte_o     (tx_byte_o),
    .ack_o         (ack_o)
  );

  assign buf_wdata_o = evt_rdata_i;
endmodule

// File: tb/i2c_txn_seq_tb.sv
module i2c_txn_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NTXN_W = 3;
  localparam int CNT_W  = 4;
  localparam int ADDR_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic              start = 1'b0;
  logic [NTXN_W-1:0] num_txn = '0;
  logic              busy, done, buf_we, evt_clr, cmd_start, cmd_restart, cmd_stop, tx_load, ack;
  logic [2:0]        result;
  logic [NTXN_W-1:0] desc_idx;
  logic [7:0]        desc_addr, buf_rdata, buf_wdata, tx_byte;
  logic [CNT_W-1:0]  desc_len;
  logic [ADDR_W-1:0] desc_base, buf_addr;
  logic              evt_valid;
  logic [3:0]        evt_code;
  logic [7:0]        evt_rdata;

  logic [7:0]        d_addr [8];
  logic [CNT_W-1:0]  d_len  [8];
  logic [ADDR_W-1:0] d_base [8];
  logic [7:0]        mem    [16];
  logic              fill_req = 1'b0;

  assign desc_addr = d_addr[desc_idx];
  assign desc_len  = d_len[desc_idx];
  assign desc_base = d_base[desc_idx];
  assign buf_rdata = mem[buf_addr];

  always @(posedge clk) begin
    if (fill_req) for (int i = 0; i < 16; i++) mem[i] <= 8'hC0 ^ 8'(i);
    else if (buf_we) mem[buf_addr] <= buf_wdata;
  end

  i2c_txn_seq #(.NTXN_W(NTXN_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .num_txn_i(num_txn),
    .busy_o(busy), .done_o(done), .result_o(result), .desc_idx_o(desc_idx),
    .desc_addr_i(desc_addr), .desc_len_i(desc_len), .desc_base_i(desc_base),
    .buf_addr_o(buf_addr), .buf_rdata_i(buf_rdata), .buf_we_o(buf_we), .buf_wdata_o(buf_wdata),
    .evt_valid_i(evt_valid), .evt_code_i(evt_code), .evt_rdata_i(evt_rdata), .evt_clr_o(evt_clr),
    .cmd_start_o(cmd_start), .cmd_restart_o(cmd_restart), .cmd_stop_o(cmd_stop),
    .tx_load_o(tx_load), .tx_byte_o(tx_byte), .ack_o(ack)
  );

  // engine model script
  int   anak_txn = -1, wnak_txn = -1, wnak_pos = -1;
  logic bad_code = 1'b0;
  // engine model state
  int   tcount = 0, wcount = 0, rcount = 0, ev_cnt = 0, cur_pos = 0;
  logic rd_mode = 1'b0, addr_phase = 1'b0;
  logic [7:0] alog [8];
  logic [7:0] wlog [32];
  logic       ack_log [32];

  task automatic post(input logic [3:0] c);
    evt_valid = 1'b1;
    evt_code  = c;
    ev_cnt++;
  endtask

  initial begin
    evt_valid = 1'b0;
    evt_code  = '0;
    evt_rdata = '0;
    forever begin
      @(negedge clk);
      if (cmd_stop) begin
        evt_valid = 1'b0;
        rd_mode   = 1'b0;
      end else if (cmd_start || cmd_restart) begin
        if (cmd_start) begin
          tcount = 0; wcount = 0; rcount = 0;
        end
        post(cmd_start ? 4'd1 : 4'd2);
        addr_phase = 1'b1;
      end else if (evt_clr) begin
        if (tx_load) begin
          if (addr_phase) begin
            addr_phase = 1'b0;
            if (tcount < 8) alog[tcount] = tx_byte;
            rd_mode = tx_byte[0];
            cur_pos = 0;
            if (bad_code) post(4'd7);
            else if (tcount == anak_txn) post(rd_mode ? 4'd9 : 4'd4);
            else post(rd_mode ? 4'd8 : 4'd3);
            tcount++;
          end else begin
            if (wcount < 32) wlog[wcount] = tx_byte;
            wcount++;
            if (tcount - 1 == wnak_txn && cur_pos == wnak_pos) post(4'd6);
            else post(4'd5);
            cur_pos++;
          end
        end else if (rd_mode && rcount < 32) begin
          ack_log[rcount] = ack;
          evt_rdata = 8'h40 + 8'(rcount);
          rcount++;
          post(ack ? 4'd10 : 4'd11);
        end else begin
          evt_valid = 1'b0;
        end
      end
    end
  end

  // monitor, sampled just after the clock edge
  int n_start = 0, n_restart = 0, n_stop = 0, n_done = 0, n_clr = 0, n_busy = 0;
  logic [2:0] last_res = '0;
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (cmd_start)   n_start++;
      if (cmd_restart) n_restart++;
      if (cmd_stop)    n_stop++;
      if (evt_clr)     n_clr++;
      if (busy)        n_busy++;
      if (done) begin
        n_done++;
        last_res = result;
      end
    end
  end

  int checks = 0, errors = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_txn(input int i, input logic [7:0] a, input int len, input int base);
    d_addr[i] = a;
    d_len[i]  = CNT_W'(len);
    d_base[i] = ADDR_W'(base);
  endtask

  task automatic fill();
    @(negedge clk) fill_req = 1'b1;
    @(negedge clk) fill_req = 1'b0;
  endtask

  task automatic clear_script();
    anak_txn = -1; wnak_txn = -1; wnak_pos = -1; bad_code = 1'b0;
  endtask

  int s_start, s_restart, s_stop, s_clr, s_ev, s_busy;

  task automatic run(input int n, input bit extra_start);
    int d0;
    bit got;
    d0 = n_done;
    s_start = n_start; s_restart = n_restart; s_stop = n_stop;
    s_clr = n_clr; s_ev = ev_cnt; s_busy = n_busy;
    @(negedge clk);
    num_txn = NTXN_W'(n);
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (extra_start) begin
      repeat (3) @(negedge clk);
      num_txn = NTXN_W'(1);
      start   = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    got = 1'b0;
    for (int k = 0; k < 3000; k++) begin
      if (n_done != d0) begin
        got = 1'b1;
        break;
      end
      @(negedge clk);
    end
    chk("R11 watchdog: done seen", int'(got), 1);
    repeat (3) @(negedge clk);
    chk("R11 single done pulse", n_done - d0, 1);
    chk("R11 result held", int'(result), int'(last_res));
    chk("R2 busy low after done", int'(busy), 0);
    chk("R10 one clear per event", n_clr - s_clr, ev_cnt - s_ev);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) set_txn(i, 8'h00, 0, 0);
    repeat (3) @(negedge clk);
    chk("R11 reset done", int'(done), 0);
    chk("R2 reset busy", int'(busy), 0);
    chk("R11 reset result", int'(result), 0);
    chk("R8 reset commands", int'({cmd_start, cmd_restart, cmd_stop, tx_load}), 0);
    rst_n = 1'b1;
    fill();

    // R1: zero-length list
    run(0, 1'b0);
    chk("R1 result OK", int'(last_res), 0);
    chk("R1 no start cmd", n_start - s_start, 0);
    chk("R1 no stop cmd", n_stop - s_stop, 0);
    chk("R1 busy never high", n_busy - s_busy, 0);

    // R4 R7 R8 R3: sweep of write/read/write chains
    for (int a = 0; a <= 4; a++) begin
      for (int b = 0; b <= 4; b++) begin
        clear_script();
        set_txn(0, 8'hA0, a, 0);
        set_txn(1, 8'hA1, b, 8);
        set_txn(2, 8'h3C, 1, 12);
        fill();
        run(3, 1'b0);
        chk("R8 chain result OK", int'(last_res), 0);
        chk("R8 restarts", n_restart - s_restart, 2);
        chk("R8 single stop", n_stop - s_stop, 1);
        chk("R2 single start", n_start - s_start, 1);
        chk("R3 addr txn0", int'(alog[0]), 8'hA0);
        chk("R3 addr txn1", int'(alog[1]), 8'hA1);
        chk("R3 addr txn2", int'(alog[2]), 8'h3C);
        chk("R4 write count", wcount, a + 1);
        for (int i = 0; i < a; i++)
          chk("R4 write byte", int'(wlog[i]), int'(8'hC0 ^ 8'(i)));
        chk("R4 last txn byte", int'(wlog[a]), int'(8'hC0 ^ 8'd12));
        chk("R7 read count", rcount, b);
        for (int i = 0; i < b; i++) begin
          chk("R7 stored byte", int'(mem[8 + i]), int'(8'h40 + 8'(i)));
          chk("R7 ack level", int'(ack_log[i]), (i < b - 1) ? 1 : 0);
        end
        if (b < 4) chk("R7 byte past area untouched", int'(mem[8 + b]), int'(8'hC0 ^ 8'(8 + b)));
      end
    end

    // R6: write address NAK on first descriptor
    clear_script();
    set_txn(0, 8'hA0, 2, 0); set_txn(1, 8'hA1, 2, 8); set_txn(2, 8'h3C, 1, 12);
    fill();
    anak_txn = 0;
    run(3, 1'b0);
    chk("R6 write addr NAK result", int'(last_res), 1);
    chk("R6 no restart", n_restart - s_restart, 0);
    chk("R6 stop", n_stop - s_stop, 1);
    chk("R6 one address", tcount, 1);
    chk("R6 no data written", wcount, 0);

    // R6: read address NAK on second descriptor
    clear_script();
    fill();
    anak_txn = 1;
    run(3, 1'b0);
    chk("R6 read addr NAK result", int'(last_res), 2);
    chk("R6 addresses before abort", tcount, 2);
    chk("R6 one restart", n_restart - s_restart, 1);
    chk("R6 no read bytes", rcount, 0);
    chk("R6 buffer untouched", int'(mem[8]), int'(8'hC0 ^ 8'd8));

    // R5: NAK on a middle written byte
    clear_script();
    set_txn(0, 8'hA0, 4, 0);
    fill();
    wnak_txn = 0; wnak_pos = 1;
    run(1, 1'b0);
    chk("R5 early NAK result", int'(last_res), 3);
    chk("R5 bytes sent before abort", wcount, 2);
    chk("R5 stop", n_stop - s_stop, 1);

    // R5: NAK on final written byte continues
    clear_script();
    set_txn(0, 8'hA0, 3, 0); set_txn(1, 8'hA1, 1, 8);
    fill();
    wnak_txn = 0; wnak_pos = 2;
    run(2, 1'b0);
    chk("R5 last-byte NAK result", int'(last_res), 0);
    chk("R5 continues with restart", n_restart - s_restart, 1);
    chk("R5 all bytes sent", wcount, 3);
    chk("R7 single read NAKed", int'(ack_log[0]), 0);
    chk("R7 single read stored", int'(mem[8]), 8'h40);

    // R9: unknown status code
    clear_script();
    set_txn(0, 8'hA0, 2, 0);
    fill();
    bad_code = 1'b1;
    run(1, 1'b0);
    chk("R9 internal error result", int'(last_res), 4);
    chk("R9 stop", n_stop - s_stop, 1);
    chk("R9 nothing written", wcount, 0);

    // R2: start while busy is ignored
    clear_script();
    set_txn(0, 8'hA0, 3, 0); set_txn(1, 8'hA1, 3, 8); set_txn(2, 8'h3C, 2, 12);
    fill();
    run(3, 1'b1);
    chk("R2 second start ignored", n_start - s_start, 1);
    chk("R2 list ran to end", n_restart - s_restart, 2);
    chk("R2 result OK", int'(last_res), 0);
    chk("R2 all writes", wcount, 5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule